// File: doc/BRIEF.md
# Stereo Transmit Sample Queue with Underrun Lockstep

This block buffers outgoing stereo audio samples between a processor and a serial audio transmitter. The processor pushes left samples and right samples into two separate queues, each with its own write and read pointers. The transmitter drains them with read strobes that alternate between the left side and the right side. A queue is read one slot at a time. The block returns each sample one clock after its strobe, together with a valid flag.

A strobe can reach a side whose queue is empty. Nothing leaves that queue, the output slot carries zero and a sticky underrun flag for that side is raised. The block then cancels the next strobe to the opposite side. The sample waiting there stays in its queue, so the left and right samples that go out next still belong to the same stereo frame. The cancellation covers one strobe only. Each underrun flag stays set until software writes a one to the clear input for that side.

Top module: `stereo_txq`

## Requirements
- R1: After a synchronous reset both queues are empty and both full flags are low. Both underrun flags are low, `rd_valid` is 0 and `rd_data` is zero.
- R2: Each side returns its samples in the order they were written, independently of the other side. A strobe to a non-empty side that is not blocked drives `rd_valid`=1 with that sample on `rd_data` in the cycle after the strobe.
- R3: A side holds at most DEPTH samples, and its full flag is high exactly when DEPTH samples are stored. A write to a side that is full at the start of the cycle is dropped, even when a read empties a slot of that side in the same cycle.
- R4: A strobe to an empty side that is not blocked removes nothing. In the next cycle it gives `rd_valid`=0 and `rd_data`=0, and it sets that side's underrun flag.
- R5: After a left underrun, the next strobe to the right side is cancelled. That strobe removes nothing, gives `rd_valid`=0 and `rd_data`=0 in the next cycle, and does not set the right underrun flag.
- R6: After a right underrun, the next strobe to the left side is cancelled in the same way.
- R7: Cancellation applies to one strobe only; the next strobe to that side behaves per R2 or R4.
- R8: An underrun flag stays set until a cycle with its clear input at 1. That cycle clears the flag unless an underrun on the same side occurs in the same cycle, which keeps it set.
- R9: `rd_side`=0 selects the left queue and `rd_side`=1 selects the right queue.
- R10: A write and a read to the same empty side in one cycle count as an underrun for the read. The written sample is kept.
- R11: In any cycle after a cycle with no read strobe, `rd_valid` is 0 and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_left_en | input | 1 | Push `wr_left_data` into the left queue |
| wr_left_data | input | DATA_W | Left sample to store |
| wr_right_en | input | 1 | Push `wr_right_data` into the right queue |
| wr_right_data | input | DATA_W | Right sample to store |
| rd_req | input | 1 | Read strobe from the transmitter |
| rd_side | input | 1 | Side of the strobe: 0 left, 1 right |
| clr_left | input | 1 | Write-one-to-clear of the left underrun flag |
| clr_right | input | 1 | Write-one-to-clear of the right underrun flag |
| rd_valid | output | 1 | A sample left a queue for the previous strobe |
| rd_data | output | DATA_W | Sample for the previous strobe, zero if none |
| left_full | output | 1 | Left queue holds DEPTH samples |
| right_full | output | 1 | Right queue holds DEPTH samples |
| ur_left | output | 1 | Sticky left underrun flag |
| ur_right | output | 1 | Sticky right underrun flag |

## Verification
The result of a strobe appears on `rd_valid` and `rd_data` exactly one clock after the strobe. The underrun flags, the full flags and the cancel state also change one clock after the cycle that causes them. The bench applies every stimulus just after a falling edge. It updates its own queue and flag model for that cycle, lets one rising edge pass, and compares all outputs at the next falling edge. Every check therefore lands in the cycle in which the result is due. Directed cases cover underrun on each side, single-strobe cancellation, clear against a simultaneous set, overfill and the same-cycle write and read. A long strict left-right random run with random writes and clears then follows.

// File: rtl/stq_pkg.sv
package stq_pkg;
  localparam int NUM_HALVES = 2;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } stq_side_e;
endpackage

// File: rtl/stq_half_fifo.sv
module stq_half_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count;
  logic              do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // Storage without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (do_pop) pop_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/stq_lockstep.sv
module stq_lockstep
  import stq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_req,
  input  logic                  rd_side,
  input  logic [NUM_HALVES-1:0] empty,
  input  logic [NUM_HALVES-1:0] clr,
  output logic [NUM_HALVES-1:0] pop,
  output logic                  deliver,
  output logic [NUM_HALVES-1:0] ur,
  output logic [NUM_HALVES-1:0] blk
);
  logic                  sel, other;
  logic                  blocked, hit_empty, underrun;
  logic [NUM_HALVES-1:0] blk_n, ur_set;

  always_comb begin
    sel       = rd_side;
    other     = (sel == SIDE_LEFT) ? SIDE_RIGHT : SIDE_LEFT;
    blocked   = blk[sel];
    hit_empty = empty[sel];
    underrun  = rd_req && !blocked && hit_empty;
    deliver   = rd_req && !blocked && !hit_empty;

    pop      = '0;
    pop[sel] = deliver;

    ur_set      = '0;
    ur_set[sel] = underrun;

    blk_n = blk;
    if (rd_req && blocked) blk_n[sel] = 1'b0;
    if (underrun)          blk_n[other] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk <= '0;
      ur  <= '0;
    end else begin
      blk <= blk_n;
      ur  <= (ur & ~clr) | ur_set;
    end
  end
endmodule

// File: rtl/stereo_txq.sv
module stereo_txq
  import stq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_left_en,
  input  logic [DATA_W-1:0] wr_left_data,
  input  logic              wr_right_en,
  input  logic [DATA_W-1:0] wr_right_data,
  input  logic              rd_req,
  input  logic              rd_side,
  input  logic              clr_left,
  input  logic              clr_right,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              left_full,
  output logic              right_full,
  output logic              ur_left,
  output logic              ur_right
);
  logic [NUM_HALVES-1:0] wr_en_v, pop_v, fifo_empty, fifo_full, ur_v, blk_state;
  logic [DATA_W-1:0]     wr_data_v  [NUM_HALVES];
  logic [DATA_W-1:0]     pop_data_v [NUM_HALVES];
  logic                  deliver;
  logic                  valid_q, side_q;

  assign wr_en_v      = {wr_right_en, wr_left_en};
  assign wr_data_v[0] = wr_left_data;
  assign wr_data_v[1] = wr_right_data;

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    stq_half_fifo #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W)
    ) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (wr_en_v[g]),
      .push_data (wr_data_v[g]),
      .pop       (pop_v[g]),
      .pop_data  (pop_data_v[g]),
      .empty     (fifo_empty[g]),
      .full      (fifo_full[g])
    );
  end

  stq_lockstep u_lock (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_req),
    .rd_side (rd_side),
    .empty   (fifo_empty),
    .clr     ({clr_right, clr_left}),
    .pop     (pop_v),
    .deliver (deliver),
    .ur      (ur_v),
    .blk     (blk_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      side_q  <= SIDE_LEFT;
    end else begin
      valid_q <= deliver;
      side_q  <= rd_side;
    end
  end

  assign rd_valid   = valid_q;
  assign rd_data    = valid_q ? pop_data_v[side_q] : '0;
  assign left_full  = fifo_full[0];
  assign right_full = fifo_full[1];
  assign ur_left    = ur_v[0];
  assign ur_right   = ur_v[1];
endmodule

// File: rtl/stq_checker.sv
module stq_checker #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req,
  input logic              rd_side,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_left_en,
  input logic              left_full,
  input logic              ur_left,
  input logic              clr_left,
  input logic [1:0]        fifo_empty,
  input logic [1:0]        blk_state
);
  AST_DELIVER_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    rd_req && !blk_state[rd_side] && !fifo_empty[rd_side] |=> rd_valid); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    left_full && wr_left_en && !rd_req |=> left_full); // R3

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_req && !blk_state[rd_side] && fifo_empty[rd_side] |=> !rd_valid && rd_data == '0); // R4

  AST_LEFT_UR_SETS: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_side && !blk_state[0] && fifo_empty[0] |=> ur_left); // R4

  AST_LEFT_UR_ARMS_RIGHT: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_side && !blk_state[0] && fifo_empty[0] |=> blk_state[1]); // R5

  AST_RIGHT_UR_ARMS_LEFT: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_side && !blk_state[1] && fifo_empty[1] |=> blk_state[0]); // R6

  AST_CANCEL_SILENT: assert property (@(posedge clk) disable iff (rst)
    rd_req && blk_state[rd_side] |=> !rd_valid && rd_data == '0); // R5

  AST_CANCEL_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_side && blk_state[1] |=> !blk_state[1]); // R7

  AST_UR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ur_left && !clr_left |=> ur_left); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid && rd_data == '0); // R11
endmodule

bind stereo_txq stq_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_req     (rd_req),
  .rd_side    (rd_side),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .wr_left_en (wr_left_en),
  .left_full  (left_full),
  .ur_left    (ur_left),
  .clr_left   (clr_left),
  .fifo_empty (fifo_empty),
  .blk_state  (blk_state)
);

// File: tb/sim_stereo_txq.sv
`timescale 1ns/1ps
module sim_stereo_txq;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 24;

  logic clk = 1'b0;
  logic rst;
  logic wr_left_en, wr_right_en, rd_req, rd_side, clr_left, clr_right;
  logic [DATA_W-1:0] wr_left_data, wr_right_data;
  logic rd_valid, left_full, right_full, ur_left, ur_right;
  logic [DATA_W-1:0] rd_data;

  always #4 clk = ~clk;

  stereo_txq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst),
    .wr_left_en(wr_left_en), .wr_left_data(wr_left_data),
    .wr_right_en(wr_right_en), .wr_right_data(wr_right_data),
    .rd_req(rd_req), .rd_side(rd_side),
    .clr_left(clr_left), .clr_right(clr_right),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .left_full(left_full), .right_full(right_full),
    .ur_left(ur_left), .ur_right(ur_right)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] mq0[$];
  logic [DATA_W-1:0] mq1[$];
  bit mblk[2];
  bit mur[2];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int qsize(input int s);
    return (s == 0) ? mq0.size() : mq1.size();
  endfunction

  // One cycle: drive at a falling edge, model, pass a rising edge, check at the next falling edge.
  task automatic cyc(input bit wl, input logic [DATA_W-1:0] dl,
                     input bit wrr, input logic [DATA_W-1:0] dr,
                     input bit rq, input bit side, input bit cl, input bit cr,
                     input string tag);
    bit exp_v = 1'b0;
    logic [DATA_W-1:0] exp_d = '0;
    bit set_ur[2] = '{1'b0, 1'b0};
    int sz0 = mq0.size();
    int sz1 = mq1.size();
    int s = side;
    wr_left_en = wl; wr_left_data = dl;
    wr_right_en = wrr; wr_right_data = dr;
    rd_req = rq; rd_side = side;
    clr_left = cl; clr_right = cr;
    if (rq) begin
      if (mblk[s]) mblk[s] = 1'b0;
      else if (qsize(s) == 0) begin
        set_ur[s] = 1'b1;
        mblk[1 - s] = 1'b1;
      end else begin
        exp_v = 1'b1;
        exp_d = (s == 0) ? mq0.pop_front() : mq1.pop_front();
      end
    end
    mur[0] = (mur[0] && !cl) || set_ur[0];
    mur[1] = (mur[1] && !cr) || set_ur[1];
    if (wl && sz0 < DEPTH) mq0.push_back(dl);
    if (wrr && sz1 < DEPTH) mq1.push_back(dr);
    @(posedge clk);
    @(negedge clk);
    chk(rd_valid == exp_v, {tag, " valid"}, 32'(rd_valid), 32'(exp_v));
    chk(rd_data == exp_d, {tag, " data"}, 32'(rd_data), 32'(exp_d));
    chk(ur_left == mur[0], {tag, " R8 ur_left"}, 32'(ur_left), 32'(mur[0]));
    chk(ur_right == mur[1], {tag, " R8 ur_right"}, 32'(ur_right), 32'(mur[1]));
    chk(left_full == (mq0.size() == DEPTH), {tag, " R3 left_full"}, 32'(left_full), 32'(mq0.size() == DEPTH));
    chk(right_full == (mq1.size() == DEPTH), {tag, " R3 right_full"}, 32'(right_full), 32'(mq1.size() == DEPTH));
  endtask

  task automatic idle(input string tag);
    cyc(0, '0, 0, '0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit side_t;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    wr_left_en = 0; wr_right_en = 0; rd_req = 0; rd_side = 0;
    clr_left = 0; clr_right = 0; wr_left_data = '0; wr_right_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(rd_valid == 0, "R1 rd_valid", 32'(rd_valid), 0);
    chk(rd_data == '0, "R1 rd_data", 32'(rd_data), 0);
    chk({ur_left, ur_right} == 2'b00, "R1 underrun flags", 32'({ur_left, ur_right}), 0);
    chk({left_full, right_full} == 2'b00, "R1 full flags", 32'({left_full, right_full}), 0);

    // R4, R5, R7: left underrun cancels one right strobe
    cyc(0, '0, 1, 24'hA00001, 1, 0, 0, 0, "R4 left empty read");
    cyc(0, '0, 0, '0, 1, 1, 0, 0, "R5 right strobe cancelled");
    cyc(0, '0, 0, '0, 1, 1, 0, 0, "R7 right strobe after cancel");
    idle("R11 idle after reads");
    // R8: clear, then set wins over clear
    cyc(0, '0, 0, '0, 0, 0, 1, 0, "R8 clear left");
    cyc(0, '0, 0, '0, 1, 0, 1, 0, "R8 set beats clear");
    cyc(0, '0, 0, '0, 1, 1, 0, 1, "R8 cancelled right, clear right");
    // R6: right underrun cancels one left strobe
    cyc(1, 24'h5B0002, 0, '0, 1, 1, 0, 0, "R6 right empty read");
    cyc(0, '0, 0, '0, 1, 0, 0, 0, "R6 left strobe cancelled");
    cyc(0, '0, 0, '0, 1, 0, 0, 0, "R7 R9 left strobe after cancel");
    cyc(0, '0, 0, '0, 0, 0, 1, 1, "R8 clear both");
    // R3: overfill left, then drain in order
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, DATA_W'(24'h100 + i), 0, '0, 0, 0, 0, 0, "R3 fill left");
    cyc(1, 24'hBAD, 0, '0, 1, 0, 0, 0, "R3 write while full with read");
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, '0, 0, '0, 1, 0, 0, 0, "R2 R9 drain left");
    // R10: write and read same empty side
    cyc(0, '0, 0, '0, 0, 0, 1, 1, "R8 clear both");
    cyc(0, '0, 0, '0, 1, 1, 0, 0, "R5 pending right cancel");
    cyc(0, '0, 1, 24'hC0FFEE, 1, 1, 0, 0, "R10 right write and read on empty");
    cyc(0, '0, 0, '0, 1, 0, 0, 0, "R6 left cancel after R10");
    cyc(0, '0, 0, '0, 1, 1, 0, 0, "R10 stored sample read");
    idle("R11 idle");

    // Random strict left-right traffic
    side_t = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      bit rq = ($urandom_range(99) < 55);
      cyc(($urandom_range(99) < 30), DATA_W'($urandom), ($urandom_range(99) < 30), DATA_W'($urandom),
          rq, side_t, ($urandom_range(99) < 6), ($urandom_range(99) < 6), "R2 R4 R5 R6 random");
      if (rq) side_t = ~side_t;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule